// File: doc/BRIEF.md
# Watchdog Supervisor with Programmable Reset Pulse

This block is a supervisory watchdog. Software or another agent shows it is alive by pulling a kick input from high to low. If no such falling edge arrives within the selected window, the block drives an active-low reset output low. It holds that output low for a selectable pulse length, releases it, and starts watching again with its count at zero. A 3-bit period select chooses the window or turns the watchdog off. A 2-bit pulse select chooses the reset length. All timing is counted in ticks of a 1 ms enable input, so one tick equals one millisecond.

The control is a three-state machine. **WD_OFF** holds the output high and the count at zero. **WD_WATCH** counts ticks and accepts kicks. **WD_PULSE** holds the output low and counts pulse ticks. The transitions are:
- *arm*: WD_OFF → WD_WATCH when the period select is an active code.
- *disarm*: WD_WATCH → WD_OFF when the select becomes an off code.
- *kick*: WD_WATCH → WD_WATCH with the count cleared.
- *expire*: WD_WATCH → WD_PULSE when a tick brings the count to the window.
- *release*: WD_PULSE → WD_WATCH, or WD_PULSE → WD_OFF if the select is now off, on the tick that completes the pulse.

Top module: `wdog_supervisor`

## Requirements
- R1: Period select codes 3'b000, 3'b001 and 3'b010 disable the watchdog, and the output then stays high. Codes 3'b011, 3'b100, 3'b101, 3'b110 and 3'b111 select windows of 400, 800, 1600, 3200 and 6400 ticks.
- R2: On expiry, `rst_n_o` stays low for exactly 25, 50, 100 or 200 ticks, for pulse select 2'b00, 2'b01, 2'b10 or 2'b11.
- R3: Only a falling edge of `kick_i`, taken after a two-flop synchronizer, clears the count. A steady high level does not clear it. With a tick on every cycle, a kick driven low just after a clock edge makes the output fall 403 edges later for the 400-tick window.
- R4: If `kick_i` is held low, the watchdog free-runs and produces repeated pulses. The count is zero for the whole pulse, so each high interval between pulses equals the full window.
- R5: Falling edges of `kick_i` during a reset pulse are ignored. They neither shorten the pulse nor change the following window.
- R6: The count and the pulse length advance only on cycles where `tick_1ms` is high.
- R7: Synchronous active-high `srst` clears all state and forces `rst_n_o` high on the next clock edge, including in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle 1 ms tick enable |
| kick_i | input | 1 | Asynchronous watchdog kick; a falling edge clears the count |
| wd_period_sel | input | 3 | Window select or off code |
| rst_pulse_sel | input | 2 | Reset pulse length select |
| rst_n_o | output | 1 | Active-low supervisory reset |

## Verification
The only output is the reset line, so every internal fault shows up as a change in the timing of its edges. A count that is not cleared on release, or that keeps moving during the pulse, shortens the high interval that follows. A pulse counter that is stepped without a tick, or ended by a kick, changes the low width within one pulse. A wrong synchronizer depth or edge polarity moves the fall by a cycle, or loses it entirely, within one window after the kick. Measuring both widths and the exact cycle of each fall therefore exposes these faults within one window plus one pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int WD_SEL_W    = 3;
    localparam int PU_SEL_W    = 2;
    localparam int WD_FIRST_ON = 3;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_WATCH = 2'd1,
        WD_PULSE = 2'd2
    } wd_state_e;

endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic kick_i,
    output logic fall_o
);

    // chain[0..STAGES-1] synchronise, chain[STAGES] remembers the last value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (srst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], kick_i};
        end
    end

    always_comb begin
        fall_o = chain[STAGES] & ~chain[STAGES-1];
    end

    // R3: a detected falling edge lasts one cycle only
    assert_fall_single_R3: assert property (@(posedge clk) disable iff (srst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/wdog_period_decode.sv
module wdog_period_decode
    import wdog_pkg::*;
#(
    parameter int BASE_TICKS = 400,
    parameter int CNT_W      = 13
) (
    input  logic [WD_SEL_W-1:0] sel_i,
    output logic                enable_o,
    output logic [CNT_W-1:0]    limit_o
);

    localparam logic [CNT_W-1:0] BASE = CNT_W'(BASE_TICKS);

    always_comb begin
        enable_o = (int'(sel_i) >= WD_FIRST_ON);
        limit_o  = '0;
        if (enable_o) begin
            limit_o = BASE << (sel_i - WD_SEL_W'(WD_FIRST_ON));
        end
    end

endmodule

// File: rtl/wdog_pulse_decode.sv
module wdog_pulse_decode
    import wdog_pkg::*;
#(
    parameter int BASE_TICKS = 25,
    parameter int CNT_W      = 8
) (
    input  logic [PU_SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0]    limit_o
);

    localparam logic [CNT_W-1:0] BASE = CNT_W'(BASE_TICKS);

    always_comb begin
        limit_o = BASE << sel_i;
    end

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int WD_BASE_TICKS    = 400,
    parameter int PULSE_BASE_TICKS = 25,
    parameter int SYNC_STAGES      = 2
) (
    input  logic                clk,
    input  logic                srst,
    input  logic                tick_1ms,
    input  logic                kick_i,
    input  logic [WD_SEL_W-1:0] wd_period_sel,
    input  logic [PU_SEL_W-1:0] rst_pulse_sel,
    output logic                rst_n_o
);

    localparam int WD_MAX   = WD_BASE_TICKS << ((1 << WD_SEL_W) - 1 - WD_FIRST_ON);
    localparam int WD_CNT_W = $clog2(WD_MAX + 1);
    localparam int PU_MAX   = PULSE_BASE_TICKS << ((1 << PU_SEL_W) - 1);
    localparam int PU_CNT_W = $clog2(PU_MAX + 1);

    wd_state_e             state, state_nx;
    logic [WD_CNT_W-1:0]   wd_cnt;
    logic [PU_CNT_W-1:0]   pu_cnt;
    logic [WD_CNT_W-1:0]   wd_limit;
    logic [PU_CNT_W-1:0]   pu_limit;
    logic                  wd_en;
    logic                  kick_fall;
    logic                  expire;
    logic                  pulse_done;

    wdog_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .srst   (srst),
        .kick_i (kick_i),
        .fall_o (kick_fall)
    );

    wdog_period_decode #(.BASE_TICKS(WD_BASE_TICKS), .CNT_W(WD_CNT_W)) u_period (
        .sel_i    (wd_period_sel),
        .enable_o (wd_en),
        .limit_o  (wd_limit)
    );

    wdog_pulse_decode #(.BASE_TICKS(PULSE_BASE_TICKS), .CNT_W(PU_CNT_W)) u_pulse (
        .sel_i   (rst_pulse_sel),
        .limit_o (pu_limit)
    );

    always_comb begin
        expire     = ({1'b0, wd_cnt} + 1'b1) >= {1'b0, wd_limit};
        pulse_done = ({1'b0, pu_cnt} + 1'b1) >= {1'b0, pu_limit};
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            WD_OFF: begin
                if (wd_en) state_nx = WD_WATCH;
            end
            WD_WATCH: begin
                if (!wd_en)                      state_nx = WD_OFF;
                else if (kick_fall)              state_nx = WD_WATCH;
                else if (tick_1ms && expire)     state_nx = WD_PULSE;
            end
            WD_PULSE: begin
                if (tick_1ms && pulse_done) state_nx = wd_en ? WD_WATCH : WD_OFF;
            end
            default: state_nx = WD_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (srst) state <= WD_OFF;
        else      state <= state_nx;
    end

    // counters
    always_ff @(posedge clk) begin
        if (srst) begin
            wd_cnt <= '0;
            pu_cnt <= '0;
        end else begin
            unique case (state)
                WD_OFF: begin
                    wd_cnt <= '0;
                    pu_cnt <= '0;
                end
                WD_WATCH: begin
                    pu_cnt <= '0;
                    if (!wd_en || kick_fall)      wd_cnt <= '0;
                    else if (tick_1ms && expire)  wd_cnt <= '0;
                    else if (tick_1ms)            wd_cnt <= wd_cnt + 1'b1;
                end
                WD_PULSE: begin
                    wd_cnt <= '0;
                    if (tick_1ms) pu_cnt <= pulse_done ? '0 : pu_cnt + 1'b1;
                end
                default: begin
                    wd_cnt <= '0;
                    pu_cnt <= '0;
                end
            endcase
        end
    end

    // output logic
    always_comb begin
        unique case (state)
            WD_PULSE: rst_n_o = 1'b0;
            default:  rst_n_o = 1'b1;
        endcase
    end

    assert_off_codes_R1: assert property (@(posedge clk) disable iff (srst)
        (!wd_en && state != WD_PULSE) |=> state == WD_OFF);

    assert_pulse_holds_R2: assert property (@(posedge clk) disable iff (srst)
        (state == WD_PULSE && !tick_1ms) |=> (state == WD_PULSE && $stable(pu_cnt)));

    assert_count_frozen_R4: assert property (@(posedge clk) disable iff (srst)
        (state == WD_PULSE) |-> wd_cnt == '0);

    assert_release_zero_R4: assert property (@(posedge clk) disable iff (srst)
        $rose(rst_n_o) |-> wd_cnt == '0);

    assert_kick_ignored_R5: assert property (@(posedge clk) disable iff (srst)
        (state == WD_PULSE && kick_fall && !tick_1ms) |=> state == WD_PULSE);

    assert_tick_gate_R6: assert property (@(posedge clk) disable iff (srst)
        (state == WD_WATCH && wd_en && !tick_1ms && !kick_fall) |=> $stable(wd_cnt));

endmodule

// File: tb/wdog_supervisor_test.sv
module wdog_supervisor_test;

    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       tick = 1'b1;
    logic       kick = 1'b1;
    logic [2:0] wd_sel = 3'd0;
    logic [1:0] pu_sel = 2'd0;
    logic       rst_n;
    int         tests = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    wdog_supervisor uut (
        .clk           (clk),
        .srst          (srst),
        .tick_1ms      (tick),
        .kick_i        (kick),
        .wd_period_sel (wd_sel),
        .rst_pulse_sel (pu_sel),
        .rst_n_o       (rst_n)
    );

    // {period code, pulse code, expected high ticks (0 = off), expected low ticks}
    localparam int VEC [0:7][0:3] = '{
        '{3, 0,  400,  25},
        '{4, 1,  800,  50},
        '{5, 2, 1600, 100},
        '{6, 3, 3200, 200},
        '{7, 0, 6400,  25},
        '{0, 3,    0,   0},
        '{1, 2,    0,   0},
        '{2, 1,    0,   0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] w, input logic [1:0] p, input logic k);
        @(negedge clk);
        srst = 1'b1; wd_sel = w; pu_sel = p; kick = k; tick = 1'b1;
        repeat (3) @(negedge clk);
        srst = 1'b0;
    endtask

    task automatic wait_fall(input int maxc, output int n);
        n = 0;
        while (rst_n === 1'b1 && n < maxc) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input logic lvl, input int maxc, output int n);
        n = 0;
        while (rst_n === lvl && n < maxc) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n, lows;
        // R7: reset state
        repeat (3) @(negedge clk);
        chk(rst_n === 1'b1, "R7 reset high", int'(rst_n), 1);

        // table of windows and pulse lengths (R1, R2, R4 with kick held high: R3)
        for (int i = 0; i < 8; i++) begin
            do_reset(VEC[i][0][2:0], VEC[i][1][1:0], 1'b1);
            if (VEC[i][2] == 0) begin
                wait_fall(7000, n);
                chk(n == 7000, "R1 off code keeps reset high", n, 7000);
            end else begin
                wait_fall(VEC[i][2] + 10, n);
                measure(1'b0, 400, n);
                chk(n == VEC[i][3], "R2 pulse width", n, VEC[i][3]);
                measure(1'b1, 7000, n);
                chk(n == VEC[i][2], "R1 R3 window width", n, VEC[i][2]);
            end
        end

        // R3: exact latency of a kick through the synchronizer
        do_reset(3'd3, 2'd0, 1'b1);
        repeat (200) @(negedge clk);
        kick = 1'b0;
        lows = 0;
        for (int c = 0; c < 402; c++) begin
            @(negedge clk);
            if (rst_n !== 1'b1) lows++;
        end
        chk(lows == 0, "R3 no reset before kicked window ends", lows, 0);
        @(negedge clk);
        chk(rst_n === 1'b0, "R3 reset falls 403 edges after kick", int'(rst_n), 0);

        // R3: periodic kicks keep reset high
        do_reset(3'd3, 2'd0, 1'b1);
        lows = 0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (c % 150 == 149) kick = ~kick;
            if (rst_n !== 1'b1) lows++;
        end
        chk(lows == 0, "R3 periodic kicks prevent reset", lows, 0);

        // R4: kick held low free-runs with repeated pulses
        do_reset(3'd3, 2'd0, 1'b0);
        wait_fall(500, n);
        measure(1'b0, 400, n);
        chk(n == 25, "R4 first pulse width", n, 25);
        measure(1'b1, 1000, n);
        chk(n == 400, "R4 full window after release", n, 400);
        measure(1'b0, 400, n);
        chk(n == 25, "R4 repeated pulse", n, 25);

        // R5: kick during pulse is ignored
        do_reset(3'd3, 2'd3, 1'b1);
        wait_fall(500, n);
        n = 0;
        while (rst_n === 1'b0 && n < 400) begin
            n++;
            if (n == 50) kick = 1'b0;
            @(negedge clk);
        end
        chk(n == 200, "R5 pulse not shortened by kick", n, 200);
        measure(1'b1, 1000, n);
        chk(n == 400, "R5 window unchanged after ignored kick", n, 400);

        // R6: no counting without tick
        do_reset(3'd3, 2'd0, 1'b1);
        @(negedge clk);
        tick = 1'b0;
        lows = 0;
        for (int c = 0; c < 1000; c++) begin
            @(negedge clk);
            if (rst_n !== 1'b1) lows++;
        end
        chk(lows == 0, "R6 no expiry without tick", lows, 0);
        tick = 1'b1;
        for (int c = 0; c < 399; c++) @(negedge clk);
        chk(rst_n === 1'b1, "R6 high one tick before window", int'(rst_n), 1);
        @(negedge clk);
        chk(rst_n === 1'b0, "R6 expiry after 400 ticks", int'(rst_n), 0);

        // R7: reset in the middle of a pulse
        repeat (5) @(negedge clk);
        srst = 1'b1;
        @(negedge clk);
        chk(rst_n === 1'b1, "R7 reset ends pulse", int'(rst_n), 1);
        srst = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R7 watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule